// File: doc/BRIEF.md
# Block Transfer and Compare Engine

This engine carries out the memory block-copy and block-search operations of an 8-bit processor core. Three 16-bit registers hold a source pointer, a destination pointer and a byte count. One start pulse, with the operation kind, the stepping direction and the single or repeat choice, launches a job. Each step reads one byte through a synchronous memory port. A copy step then writes the byte to the destination. A search step instead subtracts the byte from the accumulator value. Both kinds compute a new flag byte.

A repeating job runs step after step. It ends when the count reaches zero, and a search also ends as soon as the byte equals the accumulator. A fixed idle gap sits between repeated steps, so the cycle cost matches a core that re-fetches the instruction for every iteration. A one-cycle `done` pulse tells the surrounding core that the updated pointers, count and flags are ready.

Top module: `bt_block_engine`

## Requirements
- R1: A start pulse seen while idle loads all operands. In the next cycle `mem_rd` is 1 and `mem_addr` equals the loaded source pointer.
- R2: In a copy step, the cycle after the read drives `mem_wr`=1, `mem_addr`=destination and `mem_wdata`=the byte read. A search step never asserts `mem_wr`, and its destination register stays unchanged.
- R3: Each step moves the source pointer (and, for a copy, the destination pointer) by +1 when `op_dec`=0 and by -1 when `op_dec`=1. It also lowers the count by 1. All three wrap modulo 2^16, so a count of 0 becomes 0xFFFF.
- R4: Flag bit 2 (parity/overflow) is set after a step exactly when the decremented count is non-zero.
- R5: After a copy step, bit 4 (half-carry) and bit 1 (subtract) are 0. Bits 7, 6 and 0 keep their previous values. Bit 3 is bit 3 of (accumulator + byte), and bit 5 is bit 1 of that sum.
- R6: After a search step with r = accumulator − byte: bit 7 is r[7], bit 6 is (r==0), and bit 4 is the borrow out of the low nibble. Bit 1 is 1 and bit 0 is unchanged. Bits 3 and 5 are bits 3 and 1 of (r − bit 4).
- R7: With `op_rep`=0 exactly one step runs. A repeating copy continues while bit 2 is set. A repeating search continues while bit 2 is set and bit 6 is clear.
- R8: A step occupies two cycles (read, then execute). Successive reads of a repeating job are 7 cycles apart, which is 5 extra cycles per iteration.
- R9: `done` is high for exactly one cycle, the cycle after the final step's execute cycle. The outputs already hold the final values in that cycle.
- R10: A start pulse during a running job is ignored, and the job finishes with its original operands.
- R11: After reset, `busy`, `done`, `mem_rd` and `mem_wr` are 0, and the pointer, count and flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a job when idle |
| op_cmp | input | 1 | 1 = search against accumulator, 0 = copy |
| op_dec | input | 1 | 1 = pointers step down, 0 = up |
| op_rep | input | 1 | 1 = repeat until end condition |
| acc_in | input | 8 | Accumulator value |
| flags_in | input | 8 | Flag byte before the job |
| src_in | input | 16 | Initial source pointer |
| dst_in | input | 16 | Initial destination pointer |
| cnt_in | input | 16 | Initial byte count |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe; data returns next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| src_out | output | 16 | Current source pointer |
| dst_out | output | 16 | Current destination pointer |
| cnt_out | output | 16 | Current count |
| flags_out | output | 8 | Current flag byte |

## Verification
In a repeating search, two end conditions can hit on the same step: the count reaching zero and the byte matching. The bench places the matching byte at the last counted address and checks that the job stops there with bit 6 set and bit 2 clear. It also runs a match before the count runs out, which must stop early with bit 2 still set. A second overlap is a new start arriving during a running job. The bench drives start with different operands mid-job and judges the result by the final pointers, count and memory contents, which must match an undisturbed run.

// File: rtl/bt_pkg.sv
// Package: shared constants and types for the block transfer engine.
// Assumes an 8-bit flag byte with the bit positions listed below.
package bt_pkg;
    localparam int BYTE_W = 8;
    localparam int FB_C = 0;  // carry
    localparam int FB_N = 1;  // subtract
    localparam int FB_P = 2;  // parity/overflow (count non-zero)
    localparam int FB_X = 3;  // undocumented bit 3
    localparam int FB_H = 4;  // half-carry
    localparam int FB_Y = 5;  // undocumented bit 5
    localparam int FB_Z = 6;  // zero
    localparam int FB_S = 7;  // sign

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_EXEC = 2'd2,
        ST_GAP  = 2'd3
    } bt_state_e;
endpackage

// File: rtl/bt_flag_calc.sv
// Module: combinational flag computation for one copy or search step.
// Assumes data is the byte just read and cnt_nz reflects the decremented count.
module bt_flag_calc
    import bt_pkg::*;
(
    input  logic              is_cmp,
    input  logic [BYTE_W-1:0] acc,
    input  logic [BYTE_W-1:0] data,
    input  logic [BYTE_W-1:0] flags_prev,
    input  logic              cnt_nz,
    output logic [BYTE_W-1:0] flags_new,
    output logic              keep_going
);
    logic [BYTE_W-1:0] sum_v;
    logic [BYTE_W-1:0] diff_v;
    logic [BYTE_W-1:0] adj_v;
    logic              half_b;

    // Arithmetic terms shared by both step kinds
    always_comb begin
        sum_v  = acc + data;
        diff_v = acc - data;
        half_b = (acc[3:0] < data[3:0]);
        adj_v  = diff_v - {{(BYTE_W-1){1'b0}}, half_b};
    end

    // Flag byte assembly; untouched bits pass through from flags_prev
    always_comb begin
        flags_new       = flags_prev;
        flags_new[FB_P] = cnt_nz;
        if (is_cmp) begin
            flags_new[FB_S] = diff_v[BYTE_W-1];
            flags_new[FB_Z] = (diff_v == '0);
            flags_new[FB_H] = half_b;
            flags_new[FB_N] = 1'b1;
            flags_new[FB_X] = adj_v[3];
            flags_new[FB_Y] = adj_v[1];
        end else begin
            flags_new[FB_H] = 1'b0;
            flags_new[FB_N] = 1'b0;
            flags_new[FB_X] = sum_v[3];
            flags_new[FB_Y] = sum_v[1];
        end
    end

    // Repeat continuation: count left, and for a search no match yet
    always_comb keep_going = cnt_nz && !(is_cmp && flags_new[FB_Z]);
endmodule

// File: rtl/bt_ptr_step.sv
// Module: steps a pointer up or down by one, wrapping at the width.
// Assumes the caller decides when the stepped value is stored.
module bt_ptr_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic          dec,
    output logic [AW-1:0] nxt
);
    // Select increment or decrement
    always_comb nxt = dec ? (cur - 1'b1) : (cur + 1'b1);
endmodule

// File: rtl/bt_seq.sv
// Module: step sequencer. Read cycle, execute cycle, then either an idle
// gap of GAP_CYC cycles before the next read, or finish with a done pulse.
// Assumes more_steps is valid during the execute cycle.
module bt_seq
    import bt_pkg::*;
#(
    parameter int GAP_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_cmp,
    input  logic more_steps,
    output logic busy,
    output logic mem_rd,
    output logic mem_wr,
    output logic use_dst,
    output logic step_en,
    output logic done
);
    localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

    bt_state_e      st;
    logic [GW-1:0]  gcnt;

    // State register, gap counter and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            gcnt <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) st <= ST_READ;
                ST_READ: st <= ST_EXEC;
                ST_EXEC: begin
                    if (more_steps) begin
                        if (GAP_CYC == 0) begin
                            st <= ST_READ;
                        end else begin
                            st   <= ST_GAP;
                            gcnt <= '0;
                        end
                    end else begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end
                end
                ST_GAP: begin
                    if (gcnt == GW'(GAP_CYC - 1)) st <= ST_READ;
                    else gcnt <= gcnt + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Strobe decode from state
    always_comb begin
        busy    = (st != ST_IDLE);
        mem_rd  = (st == ST_READ);
        step_en = (st == ST_EXEC);
        mem_wr  = step_en && !is_cmp;
        use_dst = mem_wr;
    end

    // R8: a read is always followed by the execute cycle
    p_read_then_exec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> step_en);
    // R9: done lasts a single cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/bt_block_engine.sv
// Module: top of the block transfer and compare engine. Holds the operand
// registers, applies step results and routes the memory port.
// Assumes a synchronous memory returning read data the cycle after mem_rd.
module bt_block_engine
    import bt_pkg::*;
#(
    parameter int AW      = 16,
    parameter int CW      = 16,
    parameter int GAP_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_cmp,
    input  logic              op_dec,
    input  logic              op_rep,
    input  logic [BYTE_W-1:0] acc_in,
    input  logic [BYTE_W-1:0] flags_in,
    input  logic [AW-1:0]     src_in,
    input  logic [AW-1:0]     dst_in,
    input  logic [CW-1:0]     cnt_in,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [AW-1:0]     src_out,
    output logic [AW-1:0]     dst_out,
    output logic [CW-1:0]     cnt_out,
    output logic [BYTE_W-1:0] flags_out
);
    logic [AW-1:0]     src_q, dst_q, src_nxt, dst_nxt;
    logic [CW-1:0]     cnt_q, cnt_dec;
    logic [BYTE_W-1:0] flg_q, acc_q, flg_new;
    logic              cmp_q, dec_q, rep_q;
    logic              accept, step_en, use_dst, keep_going;

    // Job acceptance only while idle
    always_comb begin
        accept  = start && !busy;
        cnt_dec = cnt_q - 1'b1;
    end

    bt_ptr_step #(.AW(AW)) u_src_step (.cur(src_q), .dec(dec_q), .nxt(src_nxt));
    bt_ptr_step #(.AW(AW)) u_dst_step (.cur(dst_q), .dec(dec_q), .nxt(dst_nxt));

    bt_flag_calc u_flags (
        .is_cmp     (cmp_q),
        .acc        (acc_q),
        .data       (mem_rdata),
        .flags_prev (flg_q),
        .cnt_nz     (cnt_dec != '0),
        .flags_new  (flg_new),
        .keep_going (keep_going)
    );

    bt_seq #(.GAP_CYC(GAP_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .is_cmp     (cmp_q),
        .more_steps (rep_q && keep_going),
        .busy       (busy),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .use_dst    (use_dst),
        .step_en    (step_en),
        .done       (done)
    );

    // Operand registers: load on accept, update on each execute cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0; dst_q <= '0; cnt_q <= '0; flg_q <= '0; acc_q <= '0;
            cmp_q <= 1'b0; dec_q <= 1'b0; rep_q <= 1'b0;
        end else if (accept) begin
            src_q <= src_in; dst_q <= dst_in; cnt_q <= cnt_in;
            flg_q <= flags_in; acc_q <= acc_in;
            cmp_q <= op_cmp; dec_q <= op_dec; rep_q <= op_rep;
        end else if (step_en) begin
            src_q <= src_nxt;
            if (!cmp_q) dst_q <= dst_nxt;
            cnt_q <= cnt_dec;
            flg_q <= flg_new;
        end
    end

    // Memory port and result outputs
    always_comb begin
        mem_addr  = use_dst ? dst_q : src_q;
        mem_wdata = mem_rdata;
        src_out   = src_q;
        dst_out   = dst_q;
        cnt_out   = cnt_q;
        flags_out = flg_q;
    end

    // R3: every executed step lowers the count by one
    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R4: parity/overflow mirrors a non-zero remaining count
    p_par_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (flg_q[FB_P] == (cnt_q != '0)));
    // R5: carry survives every step (R6 likewise)
    p_carry_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (flg_q[FB_C] == $past(flg_q[FB_C])));
    // R10: operands stay put while a job runs and no step executes
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step_en) |=> (src_q == $past(src_q) && cnt_q == $past(cnt_q)));
endmodule

// File: tb/bt_block_engine_tb.sv
module bt_block_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, op_cmp = 1'b0, op_dec = 1'b0, op_rep = 1'b0;
    logic [7:0]  acc_in = '0, flags_in = '0;
    logic [15:0] src_in = '0, dst_in = '0, cnt_in = '0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr, busy, done;
    logic [7:0]  mem_wdata, mem_rdata, flags_out;
    logic [15:0] src_out, dst_out, cnt_out;

    always #5 clk = ~clk;

    bt_block_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_cmp(op_cmp), .op_dec(op_dec),
        .op_rep(op_rep), .acc_in(acc_in), .flags_in(flags_in), .src_in(src_in),
        .dst_in(dst_in), .cnt_in(cnt_in), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
        .done(done), .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out),
        .flags_out(flags_out)
    );

    // Memory model: 256 bytes, preload port driven by the bench
    logic [7:0] mem [0:255];
    logic       pl_we = 1'b0;
    logic [7:0] pl_addr = '0, pl_data = '0;
    logic [7:0] rdata_q = '0;
    assign mem_rdata = rdata_q;
    always @(posedge clk) begin
        if (mem_rd) rdata_q <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        else if (pl_we) mem[pl_addr] <= pl_data;
    end

    // Monitor: counts reads, writes, done pulses and read spacing
    logic mon_clr = 1'b0;
    int   cyc = 0, rd_n = 0, wr_n = 0, dn_n = 0, last_rd = -1, rd_gap = 0;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (mon_clr) begin
            rd_n <= 0; wr_n <= 0; dn_n <= 0; last_rd <= -1; rd_gap <= 0;
        end else begin
            if (mem_rd) begin
                rd_n <= rd_n + 1;
                if (last_rd >= 0) rd_gap <= cyc - last_rd;
                last_rd <= cyc;
            end
            if (mem_wr) wr_n <= wr_n + 1;
            if (done) dn_n <= dn_n + 1;
        end
    end

    int total = 0, bad = 0;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        pl_we = 1'b1; pl_addr = a; pl_data = d;
        @(posedge clk); #1;
        pl_we = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 2000 && !done; k++) @(negedge clk);
    endtask

    task automatic run_op(input logic c, input logic d, input logic r, input logic [7:0] a,
                          input logic [7:0] f, input logic [15:0] s, input logic [15:0] t,
                          input logic [15:0] n);
        @(posedge clk); #1;
        mon_clr = 1'b1;
        op_cmp = c; op_dec = d; op_rep = r; acc_in = a; flags_in = f;
        src_in = s; dst_in = t; cnt_in = n; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0; mon_clr = 1'b0;
        @(negedge clk);
        chk("R1 first read strobe", mem_rd, 1'b1);
        chk("R1 first read address", mem_addr, s);
        wait_done();
        chk("R9 done seen", done, 1'b1);
        @(negedge clk);
        chk("R9 single done pulse", dn_n, 1);
    endtask

    task automatic t_reset();
        chk("R11 busy", busy, 0); chk("R11 done", done, 0);
        chk("R11 rd", mem_rd, 0); chk("R11 wr", mem_wr, 0);
        chk("R11 src", src_out, 0); chk("R11 cnt", cnt_out, 0);
        chk("R11 flags", flags_out, 0);
    endtask

    task automatic t_move_single_up();
        poke(8'h10, 8'h0A); poke(8'h40, 8'h00);
        run_op(0, 0, 0, 8'h05, 8'hFF, 16'h0010, 16'h0040, 16'h0001);
        chk("R2 copied byte", mem[8'h40], 8'h0A);
        chk("R3 src up", src_out, 16'h0011); chk("R3 dst up", dst_out, 16'h0041);
        chk("R3 count", cnt_out, 16'h0000);
        chk("R5 move flags", flags_out, 8'hE9);
        chk("R7 single one read", rd_n, 1);
    endtask

    task automatic t_move_zero_count_down();
        poke(8'h00, 8'h02); poke(8'h80, 8'h00);
        run_op(0, 1, 0, 8'h00, 8'h00, 16'h0000, 16'h0080, 16'h0000);
        chk("R2 copied byte", mem[8'h80], 8'h02);
        chk("R3 src wrap", src_out, 16'hFFFF); chk("R3 dst down", dst_out, 16'h007F);
        chk("R3 count wrap", cnt_out, 16'hFFFF);
        chk("R4 P set on wrap", flags_out, 8'h24);
    endtask

    task automatic t_move_repeat_up();
        poke(8'h20, 8'h01); poke(8'h21, 8'h02); poke(8'h22, 8'h03);
        poke(8'h60, 8'h00); poke(8'h61, 8'h00); poke(8'h62, 8'h00);
        run_op(0, 0, 1, 8'h00, 8'h00, 16'h0020, 16'h0060, 16'h0003);
        chk("R2 copy0", mem[8'h60], 8'h01); chk("R2 copy1", mem[8'h61], 8'h02);
        chk("R2 copy2", mem[8'h62], 8'h03);
        chk("R7 three reads", rd_n, 3); chk("R2 three writes", wr_n, 3);
        chk("R8 read spacing", rd_gap, 7);
        chk("R3 src end", src_out, 16'h0023); chk("R3 dst end", dst_out, 16'h0063);
        chk("R4 P clear at end", flags_out, 8'h20);
    endtask

    task automatic t_move_repeat_down();
        poke(8'h31, 8'hAA); poke(8'h30, 8'hBB);
        run_op(0, 1, 1, 8'h08, 8'hC1, 16'h0031, 16'h0071, 16'h0002);
        chk("R2 copy hi", mem[8'h71], 8'hAA); chk("R2 copy lo", mem[8'h70], 8'hBB);
        chk("R3 src down", src_out, 16'h002F); chk("R3 dst down", dst_out, 16'h006F);
        chk("R5 kept S Z C", flags_out, 8'hE1);
    endtask

    task automatic t_cmp_single_match();
        poke(8'h50, 8'h3C);
        run_op(1, 0, 0, 8'h3C, 8'h01, 16'h0050, 16'h1234, 16'h0005);
        chk("R6 match flags", flags_out, 8'h47);
        chk("R2 no write in search", wr_n, 0);
        chk("R2 dst untouched", dst_out, 16'h1234);
        chk("R3 count", cnt_out, 16'h0004);
    endtask

    task automatic t_cmp_half_borrow();
        poke(8'h58, 8'h01);
        run_op(1, 1, 0, 8'h10, 8'h00, 16'h0058, 16'h0000, 16'h0001);
        chk("R6 borrow flags", flags_out, 8'h3A);
        chk("R3 src down", src_out, 16'h0057);
    endtask

    task automatic t_cmp_repeat_match();
        poke(8'h90, 8'h11); poke(8'h91, 8'h22); poke(8'h92, 8'h55); poke(8'h93, 8'h66);
        run_op(1, 0, 1, 8'h55, 8'h00, 16'h0090, 16'h1234, 16'h000A);
        chk("R7 stops on match reads", rd_n, 3);
        chk("R7 src after match", src_out, 16'h0093);
        chk("R7 count after match", cnt_out, 16'h0007);
        chk("R6 match flags", flags_out, 8'h46);
    endtask

    task automatic t_cmp_repeat_exhaust();
        poke(8'hA0, 8'h00); poke(8'hA1, 8'h01);
        run_op(1, 0, 1, 8'hFF, 8'h00, 16'h00A0, 16'h0000, 16'h0002);
        chk("R7 exhaust reads", rd_n, 2);
        chk("R7 count zero", cnt_out, 16'h0000);
        chk("R6 last flags", flags_out, 8'hAA);
        chk("R8 read spacing", rd_gap, 7);
    endtask

    task automatic t_cmp_both_end();
        poke(8'hB0, 8'h01); poke(8'hB1, 8'h77);
        run_op(1, 0, 1, 8'h77, 8'h01, 16'h00B0, 16'h0000, 16'h0002);
        chk("R7 both end reads", rd_n, 2);
        chk("R7 both end flags", flags_out, 8'h43);
    endtask

    task automatic t_busy_ignore();
        poke(8'hC0, 8'h0C); poke(8'hC1, 8'h0D); poke(8'hE0, 8'h00); poke(8'hE1, 8'h00);
        poke(8'hF0, 8'h5A); poke(8'hF8, 8'h00);
        @(posedge clk); #1;
        mon_clr = 1'b1;
        op_cmp = 0; op_dec = 0; op_rep = 1; acc_in = 0; flags_in = 0;
        src_in = 16'h00C0; dst_in = 16'h00E0; cnt_in = 16'h0002; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0; mon_clr = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        src_in = 16'h00F0; dst_in = 16'h00F8; cnt_in = 16'h0001; start = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        start = 1'b0;
        wait_done();
        chk("R10 src kept", src_out, 16'h00C2);
        chk("R10 dst kept", dst_out, 16'h00E2);
        chk("R10 data copied", mem[8'hE1], 8'h0D);
        chk("R10 stray dst untouched", mem[8'hF8], 8'h00);
        @(negedge clk);
    endtask

    initial begin
        logic wd_hit;
        wd_hit = 1'b0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        fork
            begin
                repeat (3) @(posedge clk);
                #1;
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_move_single_up();
                t_move_zero_count_down();
                t_move_repeat_up();
                t_move_repeat_down();
                t_cmp_single_match();
                t_cmp_half_borrow();
                t_cmp_repeat_match();
                t_cmp_repeat_exhaust();
                t_cmp_both_end();
                t_busy_ignore();
            end
            begin
                #1_000_000;
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule